// File: doc/BRIEF.md
# UART Register and Interrupt Front End

This block is the software-visible face of a byte-wide serial channel. A processor reaches five word-aligned registers over a simple synchronous read/write bus: data, receive status, control, flag and interrupt status. Bytes arriving from the serial side are delivered on a valid-strobe byte port and queued in a small receive FIFO. A processor write to the data register emits a one-cycle byte strobe toward the transmitter.

The block tracks whether the receive FIFO is empty or full and keeps two interrupt status bits, receive and transmit. It drives a single level interrupt that is the OR of the two. Both bits are gated by a port-enable control bit. Enabling the transmit interrupt raises it at once, because the transmit side is always ready to accept a byte. A data read while the port is off, or while the FIFO is empty, returns all ones. A read that does return a byte clears the receive status register.

Bus reads are registered. Read data appears on `bus_rdata` in the cycle after the one in which `bus_sel` is high with `bus_we` low. The effects of any access take hold at that same clock edge.

Top module: `uart_regfront`

## Requirements
- R1: After reset the flag register (offset 0x18) reads 0x90, and the receive status (0x04), control (0x08) and interrupt status (0x1C) registers read 0. The `irq` output is low.
- R2: While control bit 0 (port enable) is clear, a data register (0x00) read returns 0xFFFFFFFF and removes no byte from the FIFO. A data write produces no transmit strobe.
- R3: With the port enabled, a data read returns the oldest queued byte in bits 7:0 with zeros above it, in arrival order. If no byte is queued the read returns 0xFFFFFFFF. A read that returns a byte clears the receive status register.
- R4: The receive FIFO holds 16 bytes. A byte arriving while it is full is dropped and sets the overrun bit (bit 3) of the receive status register. Any write to the receive status register clears it, whatever the data written.
- R5: The flag register shows receive-empty in bit 4 and receive-full in bit 6. Bit 7 always reads 1. Receive-empty clears when a byte is queued. Receive-full sets when 16 bytes are held. Draining the FIFO sets receive-empty and clears receive-full.
- R6: Interrupt status bit 0 (receive) sets when a byte arrives, but only if control bits 0 (port enable) and 4 (receive interrupt enable) are both set.
- R7: After a data read that returns a byte, the receive interrupt stays set if bytes remain. If the FIFO is then empty, the receive interrupt clears.
- R8: A control write with bits 0 and 5 (transmit interrupt enable) both set raises interrupt status bit 1 (transmit) at once. A control write with bit 5 clear clears it. The control register reads back only bits 0, 4 and 5.
- R9: A control write with bits 0 and 4 set raises the receive interrupt if a byte is already queued. A control write with bit 4 clear clears the receive interrupt.
- R10: A control write with bit 0 clear clears both interrupt status bits.
- R11: The `irq` output is high exactly when either interrupt status bit is set.
- R12: A data register write with the port enabled drives `tx_valid` high for one cycle, beginning the cycle after the write, with `tx_byte` equal to write data bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| rx_valid | input | 1 | Incoming byte strobe |
| rx_byte | input | 8 | Incoming byte |
| tx_valid | output | 1 | Outgoing byte strobe |
| tx_byte | output | 8 | Outgoing byte |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that a bus access is held for exactly one cycle and that `bus_addr` carries one of the five word-aligned offsets or an unmapped one. They also assume that `rx_valid` is a single-cycle pulse, sampled only when it is high. The bench drives every input on the falling edge and releases `bus_sel` and `rx_valid` one cycle later, so no access or byte is counted twice. The bench never issues a read and an arriving byte in the same cycle. The invariants that tie the receive interrupt to a non-empty FIFO and to its enable bits must nevertheless hold for any interleaving.

// File: rtl/uart_regfront_pkg.sv
package uart_regfront_pkg;
  // register byte offsets
  localparam logic [7:0] OFS_DATA  = 8'h00;
  localparam logic [7:0] OFS_RSTAT = 8'h04;
  localparam logic [7:0] OFS_CTRL  = 8'h08;
  localparam logic [7:0] OFS_FLAG  = 8'h18;
  localparam logic [7:0] OFS_ISTAT = 8'h1C;

  // control bits
  localparam int CB_PEN  = 0;
  localparam int CB_RXIE = 4;
  localparam int CB_TXIE = 5;

  // flag bits
  localparam int FB_RXEMPTY = 4;
  localparam int FB_RXFULL  = 6;
  localparam int FB_TXIDLE  = 7;

  // receive status and interrupt status bits
  localparam int SB_OVERRUN = 3;
  localparam int IB_RX      = 0;
  localparam int IB_TX      = 1;

  typedef struct packed {
    logic txie;
    logic rxie;
    logic pen;
  } ctrl_t;
endpackage

// File: rtl/uart_regfront_rxq.sv
module uart_regfront_rxq #(
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [BYTE_W-1:0] din,
  input  logic              pop,
  output logic [BYTE_W-1:0] dout,
  output logic              push_ok,
  output logic              drop,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  count_next
);
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              pop_ok;

  assign pop_ok  = pop && (count != '0);
  assign push_ok = push && ((count != CNT_W'(DEPTH)) || pop_ok);
  assign drop    = push && !push_ok;

  always_comb begin
    count_next = count;
    if (push_ok && !pop_ok) count_next = count + 1'b1;
    else if (pop_ok && !push_ok) count_next = count - 1'b1;
  end

  // storage without reset so it maps onto block RAM; read is old-data
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
    if (pop_ok) dout <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      count <= count_next;
      if (push_ok)
        wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)
        rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/uart_regfront_ictl.sv
module uart_regfront_ictl
  import uart_regfront_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  ctrl_wr,
  input  ctrl_t ctrl_wdata,
  input  logic  rstat_wr,
  input  logic  byte_in,
  input  logic  byte_drop,
  input  logic  byte_out,
  input  logic  avail_next,
  output ctrl_t ctrl,
  output logic  overrun,
  output logic  rx_int,
  output logic  tx_int,
  output logic  irq
);
  logic rx_n, tx_n, en_rx;

  assign en_rx = ctrl.pen && ctrl.rxie;

  always_comb begin
    rx_n = rx_int;
    tx_n = tx_int;
    if (byte_in && en_rx) rx_n = 1'b1;
    if (byte_out) begin
      if (!avail_next) rx_n = 1'b0;
      else if (en_rx) rx_n = 1'b1;
    end
    if (ctrl_wr) begin
      if (ctrl_wdata.pen) begin
        tx_n = ctrl_wdata.txie;
        if (!ctrl_wdata.rxie) rx_n = 1'b0;
        else if (avail_next) rx_n = 1'b1;
      end else begin
        rx_n = 1'b0;
        tx_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= '0;
      overrun <= 1'b0;
      rx_int  <= 1'b0;
      tx_int  <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl <= ctrl_wdata;
      if (byte_drop) overrun <= 1'b1;
      else if (rstat_wr || byte_out) overrun <= 1'b0;
      rx_int <= rx_n;
      tx_int <= tx_n;
      irq    <= rx_n | tx_n;
    end
  end
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_regfront_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DEPTH  = 16,
  localparam int BYTE_W = 8,
  localparam int DATA_W = 32,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              irq
);
  logic hit_data, hit_rstat, hit_ctrl, hit_flag, hit_istat;
  logic rd, wr;
  ctrl_t ctrl, ctrl_wdata;
  logic pen, rxie, rx_int, tx_int, overrun;
  logic push_ok, drop, pop;
  logic [CNT_W-1:0] rxq_count, rxq_count_next;
  logic [BYTE_W-1:0] rxq_dout;
  logic rx_empty, rx_full;
  logic [DATA_W-1:0] word_q;
  logic from_q;

  assign rd = bus_sel && !bus_we;
  assign wr = bus_sel && bus_we;
  assign hit_data  = (bus_addr == ADDR_W'(OFS_DATA));
  assign hit_rstat = (bus_addr == ADDR_W'(OFS_RSTAT));
  assign hit_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
  assign hit_flag  = (bus_addr == ADDR_W'(OFS_FLAG));
  assign hit_istat = (bus_addr == ADDR_W'(OFS_ISTAT));

  assign pen  = ctrl.pen;
  assign rxie = ctrl.rxie;
  assign pop  = rd && hit_data && pen && (rxq_count != '0);
  assign rx_empty = (rxq_count == '0);
  assign rx_full  = (rxq_count == CNT_W'(DEPTH));

  assign ctrl_wdata.pen  = bus_wdata[CB_PEN];
  assign ctrl_wdata.rxie = bus_wdata[CB_RXIE];
  assign ctrl_wdata.txie = bus_wdata[CB_TXIE];

  uart_regfront_rxq #(.BYTE_W(BYTE_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst),
    .push(rx_valid), .din(rx_byte),
    .pop(pop), .dout(rxq_dout),
    .push_ok(push_ok), .drop(drop),
    .count(rxq_count), .count_next(rxq_count_next)
  );

  uart_regfront_ictl u_ictl (
    .clk(clk), .rst(rst),
    .ctrl_wr(wr && hit_ctrl), .ctrl_wdata(ctrl_wdata),
    .rstat_wr(wr && hit_rstat),
    .byte_in(push_ok), .byte_drop(drop), .byte_out(pop),
    .avail_next(rxq_count_next != '0),
    .ctrl(ctrl), .overrun(overrun),
    .rx_int(rx_int), .tx_int(tx_int), .irq(irq)
  );

  // registered read path; FIFO head is taken from its own read register
  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      from_q <= 1'b0;
    end else if (rd) begin
      from_q <= pop;
      word_q <= '0;
      if (hit_data) word_q <= '1;
      if (hit_rstat) word_q[SB_OVERRUN] <= overrun;
      if (hit_ctrl) begin
        word_q[CB_PEN]  <= ctrl.pen;
        word_q[CB_RXIE] <= ctrl.rxie;
        word_q[CB_TXIE] <= ctrl.txie;
      end
      if (hit_flag) begin
        word_q[FB_RXEMPTY] <= rx_empty;
        word_q[FB_RXFULL]  <= rx_full;
        word_q[FB_TXIDLE]  <= 1'b1;
      end
      if (hit_istat) begin
        word_q[IB_RX] <= rx_int;
        word_q[IB_TX] <= tx_int;
      end
    end
  end

  assign bus_rdata = from_q ? {{(DATA_W - BYTE_W){1'b0}}, rxq_dout} : word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_byte  <= '0;
    end else begin
      tx_valid <= wr && hit_data && pen;
      if (wr && hit_data && pen) tx_byte <= bus_wdata[BYTE_W-1:0];
    end
  end
endmodule

// File: rtl/uart_regfront_chk.sv
module uart_regfront_chk #(
  parameter int ADDR_W = 5,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              tx_valid,
  input logic [7:0]        tx_byte,
  input logic              irq,
  input logic              pen,
  input logic              rxie,
  input logic              rx_int,
  input logic              tx_int,
  input logic [CNT_W-1:0]  rxq_count
);
  // R2
  tx_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && bus_addr == '0 && !pen) |=> !tx_valid);
  // R12
  tx_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && bus_addr == '0 && pen) |=> (tx_valid && tx_byte == $past(bus_wdata[7:0])));
  // R3
  empty_read_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_we && bus_addr == '0 && rxq_count == '0) |=> (bus_rdata == 32'hFFFF_FFFF));
  // R4
  depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
    rxq_count <= CNT_W'(DEPTH));
  // R6
  rx_int_gate_chk: assert property (@(posedge clk) disable iff (rst)
    rx_int |-> (pen && rxie));
  // R7
  rx_int_data_chk: assert property (@(posedge clk) disable iff (rst)
    rx_int |-> (rxq_count != '0));
  // R10
  pen_off_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && bus_addr == ADDR_W'(8'h08) && !bus_wdata[0]) |=> (!rx_int && !tx_int));
  // R11
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (rx_int || tx_int));
endmodule

bind uart_regfront uart_regfront_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid), .tx_byte(tx_byte),
  .irq(irq), .pen(pen), .rxie(rxie), .rx_int(rx_int), .tx_int(tx_int),
  .rxq_count(rxq_count)
);

// File: tb/uart_regfront_bench.sv
module uart_regfront_bench;
  localparam int AW = 5;
  localparam logic [AW-1:0] A_DATA = 5'h00, A_RSTAT = 5'h04, A_CTRL = 5'h08,
                            A_FLAG = 5'h18, A_ISTAT = 5'h1C;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic rx_valid = 1'b0;
  logic [7:0] rx_byte = '0, tx_byte;
  logic tx_valid, irq;
  int total = 0, failed = 0;
  logic last_txv;
  logic [7:0] last_txb;

  always #2 clk = ~clk;

  uart_regfront #(.ADDR_W(AW), .DEPTH(16)) u_uart_regfront (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    last_txv = tx_valid; last_txb = tx_byte;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic expect_reg(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset;
    expect_reg("R1 flag", A_FLAG, 32'h90);
    expect_reg("R1 rstat", A_RSTAT, 32'h0);
    expect_reg("R1 ctrl", A_CTRL, 32'h0);
    expect_reg("R1 istat", A_ISTAT, 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
  endtask

  task automatic t_disabled;
    wr(A_DATA, 32'h41);
    check("R2 no tx strobe", 32'(last_txv), 32'h0);
    push(8'h77);
    expect_reg("R5 empty cleared", A_FLAG, 32'h80);
    expect_reg("R2 disabled read", A_DATA, 32'hFFFF_FFFF);
    wr(A_CTRL, 32'h1);
    expect_reg("R2 byte kept", A_DATA, 32'h77);
    expect_reg("R3 empty read", A_DATA, 32'hFFFF_FFFF);
    expect_reg("R5 empty again", A_FLAG, 32'h90);
  endtask

  task automatic t_rx_irq;
    wr(A_CTRL, 32'h11);
    expect_reg("R6 no data", A_ISTAT, 32'h0);
    push(8'hA5);
    expect_reg("R6 rx int set", A_ISTAT, 32'h1);
    check("R11 irq high", 32'(irq), 32'h1);
    push(8'h3C);
    expect_reg("R3 first byte", A_DATA, 32'hA5);
    expect_reg("R7 int stays", A_ISTAT, 32'h1);
    expect_reg("R3 second byte", A_DATA, 32'h3C);
    expect_reg("R7 int cleared", A_ISTAT, 32'h0);
    check("R11 irq low", 32'(irq), 32'h0);
  endtask

  task automatic t_rx_gate;
    logic [31:0] v;
    wr(A_CTRL, 32'h01);
    push(8'h12);
    expect_reg("R6 gated off", A_ISTAT, 32'h0);
    wr(A_CTRL, 32'h11);
    expect_reg("R9 waiting data", A_ISTAT, 32'h1);
    wr(A_CTRL, 32'h01);
    expect_reg("R9 rxie clear", A_ISTAT, 32'h0);
    rd(A_DATA, v);
    check("R3 gated byte", v, 32'h12);
  endtask

  task automatic t_tx;
    logic [31:0] v;
    wr(A_CTRL, 32'hFFFF_FFDF);
    expect_reg("R8 no txie", A_ISTAT, 32'h0);
    wr(A_CTRL, 32'h21);
    expect_reg("R8 tx int", A_ISTAT, 32'h2);
    check("R11 irq tx", 32'(irq), 32'h1);
    expect_reg("R8 ctrl readback", A_CTRL, 32'h21);
    wr(A_DATA, 32'hCAFE_125A);
    check("R12 strobe", 32'(last_txv), 32'h1);
    check("R12 byte", 32'(last_txb), 32'h5A);
    @(negedge clk);
    check("R12 one cycle", 32'(tx_valid), 32'h0);
    wr(A_CTRL, 32'h01);
    expect_reg("R8 tx clear", A_ISTAT, 32'h0);
    push(8'h9E);
    wr(A_CTRL, 32'h31);
    expect_reg("R9 both set", A_ISTAT, 32'h3);
    wr(A_CTRL, 32'h30);
    expect_reg("R10 both clear", A_ISTAT, 32'h0);
    check("R10 irq low", 32'(irq), 32'h0);
    wr(A_CTRL, 32'h01);
    rd(A_DATA, v);
    check("R3 drain", v, 32'h9E);
  endtask

  task automatic t_full;
    logic [31:0] v;
    wr(A_CTRL, 32'h01);
    for (int i = 0; i < 16; i++) push(8'(i + 8'h20));
    expect_reg("R5 full", A_FLAG, 32'hC0);
    expect_reg("R4 no overrun yet", A_RSTAT, 32'h0);
    push(8'hEE);
    expect_reg("R4 overrun", A_RSTAT, 32'h8);
    wr(A_RSTAT, 32'h0000_1234);
    expect_reg("R4 write clears", A_RSTAT, 32'h0);
    push(8'hEF);
    expect_reg("R4 overrun again", A_RSTAT, 32'h8);
    rd(A_DATA, v);
    check("R3 oldest", v, 32'h20);
    expect_reg("R3 read clears rstat", A_RSTAT, 32'h0);
    expect_reg("R5 not full", A_FLAG, 32'h80);
    for (int i = 1; i < 16; i++) begin
      rd(A_DATA, v);
      check("R3 order", v, 32'(i + 8'h20));
    end
    expect_reg("R4 dropped byte absent", A_DATA, 32'hFFFF_FFFF);
    expect_reg("R5 drained", A_FLAG, 32'h90);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_disabled;
    t_rx_irq;
    t_rx_gate;
    t_tx;
    t_full;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule